// File: doc/BRIEF.md
# Event-Resynchronised PWM Time Base

This block is a single-channel PWM time base for a power stage that runs in critical conduction. An up-counter runs from zero to an active period and then wraps. Two compare levels set and then clear the raw output. An external comparator event, such as the inductor current crossing zero, can restart the counter from a programmable phase. The switching frequency therefore follows the inductor current and not only the period register.

The same event can capture the counter value. This gives software a measure of how long the current took to reach the threshold. Capture is allowed once per counter window. A trip input forces the output low at once, and the trip stays latched until software clears it.

Configuration goes through a valid/ready write port that never applies back-pressure. Captured values leave through a valid/ready port, and a value is held there until the consumer accepts it. The output has no dead-band shaping; a later stage adds it.

Top module: `rsync_pwm`

## Requirements
- R1: The counter starts at zero after reset and increments by one each clock. In the cycle after it reaches a value greater than or equal to the active period, it returns to zero, so one undisturbed period spans period+1 clocks.
- R2: A write to the period register (address 0) updates only a shadow copy. The active period takes the shadow value at the clock where the counter wraps, so the period that is running finishes with the old length.
- R3: Compare A (address 2) and compare B (address 3) act on the raw output `pwm_a`. The clock edge that ends a cycle in which the count equals compare A drives the output high. The edge that ends a cycle in which the count equals compare B drives it low. When both compare values match in the same cycle, the clear wins. The output is 0 after reset.
- R4: `zero_stb` is high in exactly those cycles in which the count is zero. With a nonzero period and no reload, it lasts a single cycle.
- R5: Both compare registers are shadowed. Their active copies load from the shadows at the clock edge that ends a zero-count cycle, so a write made during a period takes effect from the following period.
- R6: `evt_in` is treated as asynchronous. It passes through a two-flop synchroniser and is then edge-detected. When the sync-enable bit (bit 0 of the control register at address 4) is set, the third rising clock edge after `evt_in` rises loads the counter with the phase register (address 1, reset 0). When the bit is clear, the event does not affect the counter.
- R7: When the capture-enable bit (bit 1 of the control register) is set, an accepted event stores the count that was present in the cycle the event acted. The stored value is presented on `cap_data` with `cap_valid` from the cycle after the next zero count. `cap_valid` stays high until `cap_ready` is seen high.
- R8: After a capture is accepted, further events are ignored for capture until the counter has been zero again. Events in that interval still reload the counter if sync is enabled.
- R9: When a reload happens in a cycle where the count matches a compare value, the reload takes priority and the compare action of that cycle is suppressed.
- R10: While `trip_in` is high, `pwm_a` is low in the same cycle, whatever the compare state.
- R11: A trip is latched and keeps `pwm_a` low until a control write sets bit 2 (trip clear). A clear that arrives while `trip_in` is still high is ignored. After a clear, the output stays low until the next compare A match.
- R12: `wr_ready` is always high. A write is taken on any clock where `wr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (constant 1) |
| wr_addr | input | 3 | Register address: 0 period, 1 phase, 2 compare A, 3 compare B, 4 control |
| wr_data | input | CNT_W (16) | Write data |
| evt_in | input | 1 | Asynchronous comparator event |
| trip_in | input | 1 | Protection trip, forces the output low |
| pwm_a | output | 1 | Raw PWM output |
| zero_stb | output | 1 | High while the counter is zero |
| cap_valid | output | 1 | Captured count available |
| cap_ready | input | 1 | Consumer accepts the captured count |
| cap_data | output | CNT_W (16) | Captured count |

## Verification
The hardest case to reach from the ports is a reload that lands in the same cycle as a compare A match. The counter is not visible from outside, so the bench counts clocks from a zero strobe. It raises `evt_in` at a known count so that the synchroniser delay makes the reload fall exactly on the match. It then checks that the output never rises and that the next zero arrives early by the expected amount. The capture window is reached the same way: a second event is placed late in an already captured window, and the bench checks that the value delivered at the next zero is the first count, not the second.

// File: rtl/rsync_pwm_pkg.sv
package rsync_pwm_pkg;
  typedef enum logic [2:0] {
    REG_PERIOD = 3'd0,
    REG_PHASE  = 3'd1,
    REG_CMPA   = 3'd2,
    REG_CMPB   = 3'd3,
    REG_CTRL   = 3'd4
  } reg_addr_e;

  localparam int CTRL_SYNC_BIT    = 0;
  localparam int CTRL_CAP_BIT     = 1;
  localparam int CTRL_TRIPCLR_BIT = 2;
endpackage

// File: rtl/rsync_pwm_regs.sv
module rsync_pwm_regs
  import rsync_pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] prd_sh,
  output logic [CNT_W-1:0] phase,
  output logic [CNT_W-1:0] cmpa_sh,
  output logic [CNT_W-1:0] cmpb_sh,
  output logic             sync_en,
  output logic             cap_en,
  output logic             trip_clr
);
  logic ctrl_hit;

  assign ctrl_hit = wr_valid && (wr_addr == REG_CTRL);
  assign trip_clr = ctrl_hit && wr_data[CTRL_TRIPCLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_sh  <= CNT_W'(DEF_PERIOD);
      phase   <= '0;
      cmpa_sh <= '0;
      cmpb_sh <= '0;
      sync_en <= 1'b0;
      cap_en  <= 1'b0;
    end else if (wr_valid) begin
      case (wr_addr)
        REG_PERIOD: prd_sh  <= wr_data;
        REG_PHASE:  phase   <= wr_data;
        REG_CMPA:   cmpa_sh <= wr_data;
        REG_CMPB:   cmpb_sh <= wr_data;
        REG_CTRL: begin
          sync_en <= wr_data[CTRL_SYNC_BIT];
          cap_en  <= wr_data[CTRL_CAP_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rsync_pwm_timebase.sv
module rsync_pwm_timebase #(
  parameter int CNT_W       = 16,
  parameter int DEF_PERIOD  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_in,
  input  logic             sync_en,
  input  logic [CNT_W-1:0] prd_sh,
  input  logic [CNT_W-1:0] phase,
  output logic [CNT_W-1:0] ctr,
  output logic [CNT_W-1:0] prd_act,
  output logic             evt_pulse,
  output logic             reload,
  output logic             zero
);
  localparam int SR_W = SYNC_STAGES + 1;

  logic [SR_W-1:0] evt_sr;
  logic            wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_sr <= '0;
    else        evt_sr <= {evt_sr[SR_W-2:0], evt_in};
  end

  assign evt_pulse = evt_sr[SYNC_STAGES-1] & ~evt_sr[SYNC_STAGES];
  assign reload    = sync_en & evt_pulse;
  assign wrap      = (ctr >= prd_act);
  assign zero      = (ctr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr     <= '0;
      prd_act <= CNT_W'(DEF_PERIOD);
    end else if (reload) begin
      ctr <= phase;
    end else if (wrap) begin
      ctr     <= '0;
      prd_act <= prd_sh;
    end else begin
      ctr <= ctr + 1'b1;
    end
  end
endmodule

// File: rtl/rsync_pwm_capture.sv
module rsync_pwm_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_pulse,
  input  logic             cap_en,
  input  logic             zero,
  input  logic [CNT_W-1:0] ctr,
  input  logic             cap_ready,
  output logic             cap_valid,
  output logic [CNT_W-1:0] cap_data
);
  logic             armed;
  logic             pend;
  logic [CNT_W-1:0] shadow;
  logic             take;
  logic             xfer;

  assign take = evt_pulse && cap_en && armed;
  assign xfer = zero && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      pend   <= 1'b0;
      shadow <= '0;
    end else begin
      if (zero) armed <= 1'b1;
      if (xfer) pend  <= 1'b0;
      if (take) begin
        armed  <= 1'b0;
        pend   <= 1'b1;
        shadow <= ctr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_data  <= '0;
    end else if (xfer) begin
      cap_valid <= 1'b1;
      cap_data  <= shadow;
    end else if (cap_ready) begin
      cap_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rsync_pwm_outctl.sv
module rsync_pwm_outctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ctr,
  input  logic             zero,
  input  logic [CNT_W-1:0] cmpa_sh,
  input  logic [CNT_W-1:0] cmpb_sh,
  input  logic             reload,
  input  logic             trip_in,
  input  logic             trip_clr,
  output logic [CNT_W-1:0] cmpa_act,
  output logic             pwm_q,
  output logic             trip_lat,
  output logic             pwm_a
);
  logic [CNT_W-1:0] cmpb_act;
  logic             tripped;

  assign tripped = trip_in | trip_lat;
  assign pwm_a   = pwm_q & ~tripped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpa_act <= '0;
      cmpb_act <= '0;
    end else if (zero) begin
      cmpa_act <= cmpa_sh;
      cmpb_act <= cmpb_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trip_lat <= 1'b0;
    else if (trip_in)  trip_lat <= 1'b1;
    else if (trip_clr) trip_lat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pwm_q <= 1'b0;
    else if (tripped)          pwm_q <= 1'b0;
    else if (reload)           pwm_q <= pwm_q;
    else if (ctr == cmpb_act)  pwm_q <= 1'b0;
    else if (ctr == cmpa_act)  pwm_q <= 1'b1;
  end
endmodule

// File: rtl/rsync_pwm.sv
module rsync_pwm #(
  parameter int CNT_W       = 16,
  parameter int DEF_PERIOD  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             evt_in,
  input  logic             trip_in,
  output logic             pwm_a,
  output logic             zero_stb,
  output logic             cap_valid,
  input  logic             cap_ready,
  output logic [CNT_W-1:0] cap_data
);
  logic [CNT_W-1:0] prd_sh, phase, cmpa_sh, cmpb_sh;
  logic [CNT_W-1:0] ctr, prd_act, cmpa_act;
  logic             sync_en, cap_en, trip_clr;
  logic             evt_pulse, reload, pwm_q, trip_lat;

  assign wr_ready = 1'b1;

  rsync_pwm_regs #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prd_sh(prd_sh), .phase(phase), .cmpa_sh(cmpa_sh),
    .cmpb_sh(cmpb_sh), .sync_en(sync_en), .cap_en(cap_en), .trip_clr(trip_clr)
  );

  rsync_pwm_timebase #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD),
                       .SYNC_STAGES(SYNC_STAGES)) tb_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sync_en(sync_en),
    .prd_sh(prd_sh), .phase(phase), .ctr(ctr), .prd_act(prd_act),
    .evt_pulse(evt_pulse), .reload(reload), .zero(zero_stb)
  );

  rsync_pwm_capture #(.CNT_W(CNT_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cap_en(cap_en),
    .zero(zero_stb), .ctr(ctr), .cap_ready(cap_ready),
    .cap_valid(cap_valid), .cap_data(cap_data)
  );

  rsync_pwm_outctl #(.CNT_W(CNT_W)) out_i (
    .clk(clk), .rst_n(rst_n), .ctr(ctr), .zero(zero_stb),
    .cmpa_sh(cmpa_sh), .cmpb_sh(cmpb_sh), .reload(reload),
    .trip_in(trip_in), .trip_clr(trip_clr), .cmpa_act(cmpa_act),
    .pwm_q(pwm_q), .trip_lat(trip_lat), .pwm_a(pwm_a)
  );
endmodule

// File: rtl/rsync_pwm_chk.sv
module rsync_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] ctr,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] phase,
  input logic [CNT_W-1:0] cmpa_act,
  input logic             reload,
  input logic             pwm_q,
  input logic             trip_lat,
  input logic             trip_in,
  input logic             pwm_a,
  input logic             zero_stb,
  input logic             cap_valid,
  input logic             cap_ready
);
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && ctr < prd_act) |=> ctr == CNT_W'($past(ctr) + 1'b1)); // R1
  AST_CTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && ctr >= prd_act) |=> ctr == '0); // R1
  AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reload || ctr < prd_act) |=> $stable(prd_act)); // R2
  AST_ZERO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_stb && prd_act != '0 && !reload) |=> !zero_stb); // R4
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr != '0) |=> $stable(cmpa_act)); // R5
  AST_RELOAD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> ctr == $past(phase)); // R6
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> cap_valid); // R7
  AST_RELOAD_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !trip_in && !trip_lat) |=> pwm_q == $past(pwm_q)); // R9
  AST_TRIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    trip_in |-> !pwm_a); // R10
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trip_in) |-> !pwm_a); // R11
endmodule

bind rsync_pwm rsync_pwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctr(ctr), .prd_act(prd_act), .phase(phase),
  .cmpa_act(cmpa_act), .reload(reload), .pwm_q(pwm_q), .trip_lat(trip_lat),
  .trip_in(trip_in), .pwm_a(pwm_a), .zero_stb(zero_stb),
  .cap_valid(cap_valid), .cap_ready(cap_ready)
);

// File: tb/rsync_pwm_tb_top.sv
module rsync_pwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int WD_CYCLES  = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             evt_in = 1'b0;
  logic             trip_in = 1'b0;
  logic             pwm_a, zero_stb, cap_valid;
  logic             cap_ready = 1'b0;
  logic [CNT_W-1:0] cap_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsync_pwm #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .evt_in(evt_in), .trip_in(trip_in),
    .pwm_a(pwm_a), .zero_stb(zero_stb), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_data(cap_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (!zero_stb);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!zero_stb);
  endtask

  task automatic t_reset();
    int g;
    chk(pwm_a == 1'b0, "R3 reset output", pwm_a, 0);
    chk(zero_stb == 1'b1, "R4 reset zero", zero_stb, 1);
    chk(cap_valid == 1'b0, "R7 reset cap_valid", cap_valid, 0);
    chk(wr_ready == 1'b1, "R12 wr_ready", wr_ready, 1);
    step(1);
    chk(zero_stb == 1'b0, "R4 single cycle", zero_stb, 0);
    gap(g);
    chk(g == 1000, "R1 default period", g, 1000);
  endtask

  task automatic t_period();
    int g;
    wr(3'd0, 9); wr(3'd2, 2); wr(3'd3, 6);
    wait_zero();
    gap(g);
    chk(g == 10, "R1 period 9 spans 10", g, 10);
    wr(3'd0, 4);
    gap(g);
    chk(g == 8, "R2 running period keeps old length", g, 8);
    gap(g);
    chk(g == 5, "R2 new period after wrap", g, 5);
    wr(3'd0, 9);
    wait_zero();
    gap(g);
    chk(g == 10, "R2 period restored", g, 10);
  endtask

  task automatic t_wave();
    wait_zero();
    for (int k = 1; k <= 10; k++) begin
      step(1);
      chk(pwm_a == ((k >= 3 && k <= 6) ? 1'b1 : 1'b0), "R3 waveform",
          pwm_a, (k >= 3 && k <= 6) ? 1 : 0);
    end
  endtask

  task automatic t_cmp_shadow();
    int hi;
    wait_zero();
    wr(3'd2, 4);
    step(1);
    chk(pwm_a == 1'b1, "R5 old compare A still active", pwm_a, 1);
    wait_zero();
    hi = 0;
    for (int k = 1; k <= 9; k++) begin
      step(1);
      if (pwm_a) hi++;
    end
    chk(hi == 2, "R5 new compare A from next period", hi, 2);
    wr(3'd2, 2);
    wait_zero();
  endtask

  task automatic t_sync_priority();
    int g, hi;
    wr(3'd0, 50); wr(3'd1, 5); wr(3'd4, 1);
    wait_zero(); wait_zero();
    evt_in = 1'b1;
    g = 0; hi = 0;
    do begin @(negedge clk); g++; if (pwm_a) hi++; end while (!zero_stb);
    evt_in = 1'b0;
    chk(g == 49, "R6 reload to phase shortens period", g, 49);
    chk(hi == 0, "R9 compare A suppressed by reload", hi, 0);
    step(3);
    chk(pwm_a == 1'b1, "R3 set without event", pwm_a, 1);
    wr(3'd4, 0);
    wait_zero();
    evt_in = 1'b1;
    gap(g);
    evt_in = 1'b0;
    chk(g == 51, "R6 event ignored with sync off", g, 51);
  endtask

  task automatic t_capture();
    int g;
    wr(3'd4, 3);
    wait_zero();
    evt_in = 1'b1;
    step(5);
    evt_in = 1'b0;
    step(5);
    evt_in = 1'b1;
    gap(g);
    evt_in = 1'b0;
    chk(g == 49, "R8 second event still reloads", g, 49);
    chk(cap_valid == 1'b0, "R7 not yet presented", cap_valid, 0);
    step(1);
    chk(cap_valid == 1'b1, "R7 presented after zero", cap_valid, 1);
    chk(cap_data == 16'd2, "R8 first count kept, second ignored", cap_data, 2);
    step(2);
    chk(cap_valid == 1'b1, "R7 held without ready", cap_valid, 1);
    cap_ready = 1'b1;
    step(1);
    cap_ready = 1'b0;
    chk(cap_valid == 1'b0, "R7 released by ready", cap_valid, 0);
    wr(3'd4, 0);
  endtask

  task automatic t_trip();
    wr(3'd3, 40);
    wait_zero(); wait_zero();
    step(5);
    chk(pwm_a == 1'b1, "R3 high before trip", pwm_a, 1);
    trip_in = 1'b1;
    #1;
    chk(pwm_a == 1'b0, "R10 immediate force low", pwm_a, 0);
    step(1);
    trip_in = 1'b0;
    step(1);
    chk(pwm_a == 1'b0, "R11 held low after trip drops", pwm_a, 0);
    wait_zero(); step(5);
    chk(pwm_a == 1'b0, "R11 latched across periods", pwm_a, 0);
    wr(3'd4, 4);
    step(1);
    chk(pwm_a == 1'b0, "R11 low until next compare A", pwm_a, 0);
    wait_zero(); step(5);
    chk(pwm_a == 1'b1, "R11 resumes after clear", pwm_a, 1);
    trip_in = 1'b1;
    wr(3'd4, 4);
    trip_in = 1'b0;
    wait_zero(); step(5);
    chk(pwm_a == 1'b0, "R11 clear ignored while trip high", pwm_a, 0);
    wr(3'd4, 4);
    wait_zero(); step(5);
    chk(pwm_a == 1'b1, "R11 second clear works", pwm_a, 1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(0);
    t_reset();
    t_period();
    t_wave();
    t_cmp_shadow();
    t_sync_priority();
    t_capture();
    t_trip();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule